// File: doc/BRIEF.md
# EEPROM Programming Status Reporter

This block sits beside the write controller of a parallel EEPROM and tells a host whether an internal programming cycle is still running. A neighbouring block supplies a busy level for the whole length of the cycle and the last byte the host loaded. This block watches the chip-enable, output-enable and write-enable strobes and a reset pin. From them it produces what a host sees while programming is in progress.

During programming, a read returns a status word instead of array contents. The top bit is the complement of the loaded byte's top bit. The next bit flips after every completed read. The low bits echo the loaded byte. An open-drain ready/busy line is pulled low from the first write strobe of a cycle until the cycle ends. The open-drain line is modelled as an enable plus a constant low level. Once busy drops, reads return array data.

While the reset pin is low, reads are blocked and the data bus floats. A reset that arrives during programming raises an abort request to the write controller.

Top module: `prog_status_reporter`

## Requirements
- R1: While busy_i is high, a read returns the inverse of last_byte_i bit 7 on dq_o bit 7.
- R2: Bit 6 of dq_o during programming shows 1 on the first read after a write strobe. It inverts once each time a read strobe ends (read condition drops) while busy_i is high. It does not change while the read is held.
- R3: While busy_i is low, a read returns array_i unchanged on all eight bits.
- R4: rdy_oe_o rises on the clock edge that sees a write strobe. A write strobe is the start of the condition ce_n_i=0, we_n_i=0, res_n_i=1. rdy_o is always 0.
- R5: rdy_oe_o drops on the first clock edge at which busy_i is seen low after having been high.
- R6: While res_n_i is low, dq_oe_o is 0 whatever the strobes are.
- R7: res_n_i low while busy_i is high drives abort_o high in the same cycle. rdy_oe_o is released on the next clock edge.
- R8: dq_oe_o is 1 only when ce_n_i=0, oe_n_i=0, we_n_i=1 and res_n_i=1.
- R9: While busy_i is high, a read returns last_byte_i bits 5..0 on dq_o bits 5..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| res_n_i | input | 1 | Device reset pin, active low |
| busy_i | input | 1 | Programming cycle in progress, from write controller |
| last_byte_i | input | 8 | Last byte loaded by the host |
| array_i | input | 8 | Array data at the read address |
| dq_o | output | 8 | Read data |
| dq_oe_o | output | 1 | Data bus drive enable |
| rdy_o | output | 1 | Ready/busy level, constant 0 |
| rdy_oe_o | output | 1 | Ready/busy pull-down enable |
| abort_o | output | 1 | Abort request to write controller |

## Verification
A toggle state stuck, inverted or advanced per clock shows up on bit 6 at the second read of a cycle. The check sits a single idle clock after the first read strobe ends. A wrong ready/busy flag appears on rdy_oe_o one edge after the write strobe, the busy fall or the reset fall. The output mux is combinational, so a wrong polling or echo bit shows in the same cycle the read begins.

// File: rtl/psr_pkg.sv
// Shared definitions for the programming status reporter.
// Assumes an 8-bit data bus by default; bit positions derive from the width.
package psr_pkg;
    localparam int unsigned DATA_W = 8;
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic res_n;
    } strobe_t;
endpackage

// File: rtl/psr_edge.sv
// Level edge tracker: registers a condition and flags its start and end.
// Assumes the condition is already synchronous to clk.
module psr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic start_o,
    output logic end_o
);
    logic level_q;

    // Hold last cycle's condition level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign start_o = level_i & ~level_q;
    assign end_o   = level_q & ~level_i;
endmodule

// File: rtl/psr_toggle.sv
// Toggle status bit: preset to 1 on a new write cycle, inverted on each
// completed read while programming. Assumes adv_i is a one-cycle pulse.
module psr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic adv_i,
    input  logic busy_i,
    output logic tog_o
);
    // Track the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog_o <= 1'b1;
        else if (restart_i)      tog_o <= 1'b1;
        else if (adv_i && busy_i) tog_o <= ~tog_o;
    end

    p_tog_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && busy_i && !restart_i) |=> (tog_o != $past(tog_o)));
    p_tog_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !restart_i) |=> $stable(tog_o));
endmodule

// File: rtl/psr_rdy.sv
// Ready/busy pull-down control: set by the first write strobe of a cycle,
// cleared when busy falls or the reset pin goes low.
module psr_rdy (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb_i,
    input  logic busy_i,
    input  logic res_n_i,
    output logic rdy_oe_o
);
    logic busy_q;

    // Remember last cycle's busy level to find its fall.
    always_ff @(posedge clk) begin
        busy_q <= busy_i;
    end

    // Pull-down enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rdy_oe_o <= 1'b0;
        else if (!res_n_i || (busy_q && !busy_i)) rdy_oe_o <= 1'b0;
        else if (wr_stb_i)                       rdy_oe_o <= 1'b1;
    end

    p_rdy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && res_n_i && !$fell(busy_i)) |=> rdy_oe_o);
    p_rdy_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |=> !rdy_oe_o);
    p_rdy_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_n_i |=> !rdy_oe_o);
endmodule

// File: rtl/psr_mux.sv
// Read data path: status word while busy, array data otherwise.
// Assumes DW >= 3 so that the polling and toggle bits both exist.
module psr_mux #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic          busy_i,
    input  logic          tog_i,
    input  logic [DW-1:0] last_i,
    input  logic [DW-1:0] arr_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o
);
    localparam int unsigned POLL_BIT = DW - 1;
    localparam int unsigned TOG_BIT  = DW - 2;

    // Select status word or array data.
    always_comb begin
        if (busy_i) dq_o = {~last_i[POLL_BIT], tog_i, last_i[TOG_BIT-1:0]};
        else        dq_o = arr_i;
    end

    assign dq_oe_o = rd_en_i;

    p_poll_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && busy_i) |-> (dq_o[POLL_BIT] != last_i[POLL_BIT]));
    p_idle_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> (dq_o == arr_i));
endmodule

// File: rtl/prog_status_reporter.sv
// Top: decodes strobes into read and write conditions and drives the
// polling bit, toggle bit and open-drain ready/busy output.
// Assumes all inputs are synchronous to clk.
module prog_status_reporter
    import psr_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    input  logic          we_n_i,
    input  logic          res_n_i,
    input  logic          busy_i,
    input  logic [DW-1:0] last_byte_i,
    input  logic [DW-1:0] array_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o,
    output logic          rdy_o,
    output logic          rdy_oe_o,
    output logic          abort_o
);
    strobe_t strb;
    logic    rd_cond, wr_cond;
    logic    wr_stb, rd_end;
    logic    unused_rd_start, unused_wr_end;
    logic    tog;

    assign strb    = '{ce_n: ce_n_i, oe_n: oe_n_i, we_n: we_n_i, res_n: res_n_i};
    assign rd_cond = !strb.ce_n && !strb.oe_n && strb.we_n && strb.res_n;
    assign wr_cond = !strb.ce_n && !strb.we_n && strb.res_n;

    psr_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .level_i(wr_cond),
                        .start_o(wr_stb), .end_o(unused_wr_end));
    psr_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .level_i(rd_cond),
                        .start_o(unused_rd_start), .end_o(rd_end));

    psr_toggle u_tog (.clk(clk), .rst_n(rst_n), .restart_i(wr_stb),
                      .adv_i(rd_end), .busy_i(busy_i), .tog_o(tog));

    psr_rdy u_rdy (.clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb),
                   .busy_i(busy_i), .res_n_i(res_n_i), .rdy_oe_o(rdy_oe_o));

    psr_mux #(.DW(DW)) u_mux (.clk(clk), .rst_n(rst_n), .rd_en_i(rd_cond),
                              .busy_i(busy_i), .tog_i(tog), .last_i(last_byte_i),
                              .arr_i(array_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o));

    assign rdy_o   = 1'b0;
    assign abort_o = busy_i && !res_n_i;

    p_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_n_i |-> !dq_oe_o);
    p_rd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_o |-> (!ce_n_i && !oe_n_i && we_n_i));
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !res_n_i) |-> abort_o);
    p_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_o && busy_i) |-> (dq_o[DW-3:0] == last_byte_i[DW-3:0]));
endmodule

// File: tb/prog_status_reporter_tb.sv
module prog_status_reporter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, res_n = 1'b1, busy = 1'b0;
    logic [7:0] last_b = 8'hA5, arr = 8'h3C;
    logic [7:0] dq;
    logic dq_oe, rdy, rdy_oe, abort;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prog_status_reporter u_dut (.clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n),
        .we_n_i(we_n), .res_n_i(res_n), .busy_i(busy), .last_byte_i(last_b),
        .array_i(arr), .dq_o(dq), .dq_oe_o(dq_oe), .rdy_o(rdy), .rdy_oe_o(rdy_oe),
        .abort_o(abort));

    // Vector: {ce_n, oe_n, we_n, busy, exp_oe, exp_dq[7:0], exp_rdy_oe}
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {4'b1110, 1'b0, 8'h00, 1'b0},  // idle
        {4'b0100, 1'b0, 8'h00, 1'b1},  // write strobe R4
        {4'b1111, 1'b0, 8'h00, 1'b1},  // busy idle
        {4'b0011, 1'b1, 8'h65, 1'b1},  // read: ~b7, tog=1, echo R1 R2 R9
        {4'b1111, 1'b0, 8'h00, 1'b1},  // read ended, toggle
        {4'b0011, 1'b1, 8'h25, 1'b1},  // tog=0 R2
        {4'b0011, 1'b1, 8'h25, 1'b1},  // held read: no change R2
        {4'b1111, 1'b0, 8'h00, 1'b1},
        {4'b0011, 1'b1, 8'h65, 1'b1},  // tog=1 R2
        {4'b1110, 1'b0, 8'h00, 1'b0},  // busy fell R5
        {4'b0010, 1'b1, 8'h3C, 1'b0},  // array data R3
        {4'b1010, 1'b0, 8'h00, 1'b0},  // ce high: no drive R8
        {4'b0110, 1'b0, 8'h00, 1'b0}   // oe high: no drive R8
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("reset R8", {7'd0, dq_oe}, 8'd0);
        chk("reset R4", {7'd0, rdy_oe}, 8'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {ce_n, oe_n, we_n, busy} = VEC[i][13:10];
            tick();
            chk($sformatf("vec%0d oe R8", i), {7'd0, dq_oe}, {7'd0, VEC[i][9]});
            if (VEC[i][9]) chk($sformatf("vec%0d dq R1/R2/R3/R9", i), dq, VEC[i][8:1]);
            chk($sformatf("vec%0d rdy R4/R5", i), {7'd0, rdy_oe}, {7'd0, VEC[i][0]});
            chk("rdy level R4", {7'd0, rdy}, 8'd0);
        end
        // R6: reset pin low blocks reads
        {ce_n, oe_n, we_n, busy} = 4'b1110;
        tick();
        res_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        tick();
        chk("R6 float", {7'd0, dq_oe}, 8'd0);
        chk("R7 no abort when idle", {7'd0, abort}, 8'd0);
        res_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        tick();
        // R7: abort during programming; new cycle also restarts toggle at 1
        last_b = 8'h5A;
        ce_n = 1'b0; we_n = 1'b0;
        tick();
        ce_n = 1'b1; we_n = 1'b1; busy = 1'b1;
        tick();
        chk("R4 second cycle", {7'd0, rdy_oe}, 8'd1);
        ce_n = 1'b0; oe_n = 1'b0;
        tick();
        chk("R1/R2 polling 5A", dq, 8'hDA);
        ce_n = 1'b1; oe_n = 1'b1;
        res_n = 1'b0;
        #1;
        chk("R7 abort same cycle", {7'd0, abort}, 8'd1);
        tick();
        chk("R7 rdy released", {7'd0, rdy_oe}, 8'd0);
        res_n = 1'b1; busy = 1'b0;
        tick();
        chk("R7 abort cleared", {7'd0, abort}, 8'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule